// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Serial Readout

This block is the digital half of one successive-approximation converter channel. A start pulse arms a circulating one-hot ring. On each rising edge of the conversion clock the ring tries one bit of the DAC control word, working down from the most significant bit. In the same edge, the bit tried one period earlier is settled from the comparator decision that was latched while the conversion clock was low. One edge after the least significant trial, that bit is settled as well and the done flag rises. The capacitor array and the comparator sit outside the block.

Once a conversion has finished, the same word register becomes one stage of a serial chain that links channels together. A separate, enabled shift clock moves the word out most significant bit first. New bits enter at the least significant end from the previous channel. The chain output passes through a flop on the falling edge of the shift clock. That flop adds half a cycle of delay, so the next channel, which samples on the rising edge, has hold margin even when the clocks of the two channels are skewed.

The register is clocked by one of two sources. The conversion clock drives it while a conversion runs. The gated shift clock drives it otherwise. The hand-over between the two sources takes place on a falling edge of the conversion clock.

Top module: `sar_seq`

## Requirements
- R1: While reset is held and right after it is released, the DAC word is 0, done is low and the serial output is 0.
- R2: The conversion clock edge that samples start high while idle clears done. On the next rising edge the DAC word becomes exactly the MSB trial, 10'h200, even if the previous word was non-zero.
- R3: Each later rising edge asserts the next lower trial bit. The same edge settles the bit tried before it: the bit is cleared if the comparator input was 1 ("too large") at the preceding falling edge, and kept otherwise. Bit i of the word has weight 2^i, so the final word equals the input the comparator was measuring against.
- R4: Done rises on the 11th rising edge after the edge that accepted start, and it is still low after the 10th. Done and the busy state are never high together.
- R5: A start pulse during a conversion has no effect, including a pulse that lands on the edge that settles the LSB. The result is unchanged and done stays high afterwards.
- R6: After done, the serial output shows the MSB of the result. Each shift clock pulse with shift enable high moves the word up one bit and brings in the serial input at bit 0. The serial output then shows the new bit 9. After 10 pulses the word equals the 10 serial-in bits, first-sent bit at position 9. With shift enable low, shift pulses do nothing.
- R7: While the result is held, further conversion clock edges and comparator changes leave the word unchanged.
- R8: Shift clock pulses during a conversion do not disturb it.
- R9: The serial output changes only on the falling edge of the shift clock. It still holds its old value between the rising and the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sar_clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, sampled on the rising edge of sar_clk |
| cmp_hi | input | 1 | Comparator decision, 1 = trial value too large |
| shift_en | input | 1 | Enables the shift clock |
| shift_clk | input | 1 | Serial chain clock |
| sin | input | 1 | Serial input from the previous channel |
| dac | output | W | DAC control word; a 1 ties that bit's positive capacitor to the top reference and its negative capacitor to the bottom reference |
| done | output | 1 | Conversion finished, word valid |
| sout | output | 1 | Serial output, retimed on the falling edge of shift_clk |

## Verification
Two pairs of events can fall in the same cycle. The first is a start request landing on the edge that settles the LSB. The bench raises start across exactly that edge and judges that the result still equals the measured input, that done stays high and that no new trial word appears. The second is shift clock activity during the conversion interval. The bench pulses the shift clock with enable high and serial input 1 during several trial periods, and the final word must still match the input exactly. A scoreboard queue holds each input the driver converts. The monitor compares it against the word and the serial output once done rises.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W = 10
) (
  input  logic         sar_clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmp_hi,
  input  logic         shift_en,
  input  logic         shift_clk,
  input  logic         sin,
  output logic [W-1:0] dac,
  output logic         done,
  output logic         sout
);
  localparam logic [W:0]   RING_LOAD = {1'b1, {W{1'b0}}};
  localparam logic [W-1:0] MSB_TRIAL = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   ring;
  logic         busy;
  logic         cmp_q;
  logic         conv_mode;
  logic         dclk;
  logic [W-1:0] nxt;

  always_ff @(posedge sar_clk or negedge rst_n) begin
    if (!rst_n) begin
      ring <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        ring <= RING_LOAD;
        busy <= 1'b1;
        done <= 1'b0;
      end
    end else begin
      ring <= ring >> 1;
      if (ring[0]) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  always_ff @(negedge sar_clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q     <= 1'b0;
      conv_mode <= 1'b0;
    end else begin
      cmp_q     <= cmp_hi;
      conv_mode <= busy;
    end
  end

  assign dclk = conv_mode ? sar_clk : (shift_clk & shift_en & ~busy);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt[i] = ring[i+1] ? 1'b1 : (ring[i] ? ~cmp_q : dac[i]);
  end

  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n)
      dac <= '0;
    else if (conv_mode)
      dac <= ring[W] ? MSB_TRIAL : nxt;
    else
      dac <= {dac[W-2:0], sin};
  end

  always_ff @(negedge dclk or negedge rst_n) begin
    if (!rst_n) sout <= 1'b0;
    else        sout <= dac[W-1];
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int W = 10
) (
  input logic       sar_clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [W:0] ring
);
  // R4
  busy_done_excl_chk: assert property (@(posedge sar_clk) disable iff (!rst_n)
    !(busy && done));

  // R3
  ring_onehot_chk: assert property (@(posedge sar_clk) disable iff (!rst_n)
    $onehot0(ring));

  // R2
  start_load_chk: assert property (@(posedge sar_clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && ring[W] && !done));

  // R3
  ring_step_chk: assert property (@(posedge sar_clk) disable iff (!rst_n)
    (busy && !ring[0]) |=> (busy && ring == ($past(ring) >> 1)));

  // R4
  finish_chk: assert property (@(posedge sar_clk) disable iff (!rst_n)
    (busy && ring[0]) |=> (done && !busy));

  // R5
  start_ignored_chk: assert property (@(posedge sar_clk) disable iff (!rst_n)
    (busy && start && !ring[0]) |=> !ring[W]);
endmodule

bind sar_seq sar_seq_chk #(.W(W)) chk_i (
  .sar_clk(sar_clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .ring   (ring)
);

// File: tb/sar_seq_tb_top.sv
module sar_seq_tb_top;
  localparam int W = 10;

  logic         sar_clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         shift_en = 1'b0;
  logic         shift_clk = 1'b0;
  logic         sin = 1'b0;
  logic [W-1:0] vin = '0;
  logic         cmp_hi;
  logic [W-1:0] dac;
  logic         done;
  logic         sout;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];

  always #10 sar_clk = ~sar_clk;

  assign cmp_hi = (dac > vin);

  sar_seq #(.W(W)) dut_i (
    .sar_clk(sar_clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi),
    .shift_en(shift_en), .shift_clk(shift_clk), .sin(sin),
    .dac(dac), .done(done), .sout(sout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the expected result when done rises
  always @(posedge done) begin
    logic [W-1:0] e;
    @(negedge sar_clk);
    #1;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R3 unexpected result", int'(dac), 0);
    end else begin
      e = exp_q.pop_front();
      chk(dac == e, "R3 converted word", int'(dac), int'(e));
      chk(sout == e[W-1], "R6 serial out shows MSB", int'(sout), int'(e[W-1]));
    end
  end

  // mode: 0 plain, 1 start mid-conversion, 2 start on LSB edge, 3 shift pulses
  task automatic do_conv(input logic [W-1:0] v, input int mode);
    vin = v;
    exp_q.push_back(v);
    @(negedge sar_clk) start = 1'b1;
    @(negedge sar_clk) start = 1'b0;
    for (int k = 1; k <= W + 1; k++) begin
      @(negedge sar_clk);
      if (k == 1) begin
        chk(dac == 10'h200, "R2 MSB trial word", int'(dac), 'h200);
        chk(done == 1'b0, "R2 done cleared", int'(done), 0);
      end
      if (k == W) chk(done == 1'b0, "R4 done low after 10th edge", int'(done), 0);
      if (k == W + 1) chk(done == 1'b1, "R4 done high after 11th edge", int'(done), 1);
      if (mode == 1 && k == 4) start = 1'b1;
      if (mode == 1 && k == 5) start = 1'b0;
      if (mode == 2 && k == W) start = 1'b1;
      if (mode == 2 && k == W + 1) start = 1'b0;
      if (mode == 3 && k >= 3 && k <= 6) begin
        shift_en = 1'b1;
        sin = 1'b1;
        #2 shift_clk = 1'b1;
        #3 shift_clk = 1'b0;
        shift_en = 1'b0;
        sin = 1'b0;
      end
    end
    #2;
    if (mode == 1 || mode == 2) begin
      repeat (3) @(negedge sar_clk);
      #2;
      chk(done == 1'b1, "R5 done stays after ignored start", int'(done), 1);
      chk(dac == v, "R5 word kept after ignored start", int'(dac), int'(v));
    end
    if (mode == 3) chk(dac == v, "R8 shift pulses ignored in conversion", int'(dac), int'(v));
  endtask

  task automatic shift_word(input logic [W-1:0] cur, input logic [W-1:0] pat);
    logic [W-1:0] m;
    logic old;
    m = cur;
    for (int k = 0; k < W; k++) begin
      sin = pat[W-1-k];
      shift_en = 1'b1;
      old = sout;
      #3 shift_clk = 1'b1;
      m = {m[W-2:0], pat[W-1-k]};
      #3;
      chk(sout == old, "R9 sout held until falling edge", int'(sout), int'(old));
      shift_clk = 1'b0;
      #3;
      chk(sout == m[W-1], "R6 serial bit", int'(sout), int'(m[W-1]));
    end
    shift_en = 1'b0;
    chk(dac == pat, "R6 shifted-in word", int'(dac), int'(pat));
    #3 shift_clk = 1'b1;
    #3 shift_clk = 1'b0;
    #3;
    chk(dac == pat, "R6 no shift with enable low", int'(dac), int'(pat));
  endtask

  initial begin
    repeat (3) @(negedge sar_clk);
    chk(dac == '0, "R1 reset word", int'(dac), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(sout == 1'b0, "R1 reset sout", int'(sout), 0);
    rst_n = 1'b1;
    @(negedge sar_clk);
    chk(dac == '0 && done == 1'b0, "R1 idle after reset", int'(dac), 0);

    do_conv(10'h000, 0);
    do_conv(10'h3FF, 0);
    do_conv(10'h155, 0);
    shift_word(10'h155, 10'h2C9);
    vin = 10'h000;
    repeat (6) @(negedge sar_clk);
    #2;
    chk(dac == 10'h2C9, "R7 conversion clock ignored in shift mode", int'(dac), 'h2C9);
    chk(done == 1'b1, "R7 done held", int'(done), 1);
    do_conv(10'h2AA, 0);
    do_conv(10'h200, 0);
    do_conv(10'h1FF, 0);
    do_conv(10'h0F3, 1);
    do_conv(10'h301, 2);
    do_conv(10'h1C7, 3);
    shift_word(10'h1C7, 10'h3A5);
    do_conv(10'h001, 0);
    #20;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule